// File: doc/BRIEF.md
# Exclusive Access Monitor for a Coherent Home Node

This block decides whether exclusive stores succeed. It sits in the home node of a coherent fabric and keeps one reservation record for each logical processor. All records are held and updated in parallel. Each processor drives its own request lane, made of a valid bit, a 2-bit kind and an address. The block accepts one lane per cycle. It then updates the records and, for an exclusive store, returns a pass or fail result on the next cycle.

A reservation names a 64-byte line. An exclusive load or an exclusive store records the line for the processor that sent it. An exclusive store passes only when that processor still holds a live reservation on the same line. A passing exclusive store removes every competing reservation on that line. A plain store removes all reservations on the line. A processor whose store fails is expected to rerun its load/store sequence.

When several lanes are valid in the same cycle, the lowest-numbered lane is accepted. The other lanes hold their request until their own accept pulse arrives.

Top module: `excl_mon_poc`

## Requirements
- R1: An accepted exclusive load (kind 01) or exclusive store (kind 10) leaves the sender with a valid reservation on the addressed line. If the sender already had a reservation, this one replaces it.
- R2: The reservations of all processors are kept at the same time. An operation by one processor on one line does not affect reservations that other processors hold on other lines.
- R3: An accepted exclusive store passes (rsp_pass=1) when, at acceptance, its sender holds a valid reservation whose line matches the store's line.
- R4: An exclusive store whose sender holds no valid reservation on that line fails (rsp_pass=0).
- R5: When an exclusive store passes, the reservations that every other processor holds on that line are cleared.
- R6: Lines are compared on address bits [ADDR_W-1:6]. Addresses that differ only in bits [5:0] refer to the same line.
- R7: Each processor holds at most one reservation. A new exclusive load to another line discards the old reservation.
- R8: An accepted normal store (kind 11) from any processor clears every reservation on its line, including the sender's own.
- R9: At most one lane is accepted per cycle, and it is always the lowest-numbered valid lane. req_ready is one-hot and marks that lane in the same cycle. Lanes that are not accepted keep their request unchanged.
- R10: Kind 00 is a no-op. It is accepted, but it changes no reservation and produces no response.
- R11: For every accepted exclusive store, rsp_valid is high in the next cycle, with rsp_lp set to the sender's lane number. No other request produces rsp_valid. rsp_pass is 0 whenever rsp_valid is 0.
- R12: Reset clears every reservation and the response outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_LP | Request pending, one bit per processor lane |
| req_kind | input | 2*NUM_LP | Request kind per lane, lane i at bits [2i+1:2i] |
| req_addr | input | ADDR_W*NUM_LP | Byte address per lane, lane i at bits [ADDR_W*i +: ADDR_W] |
| req_ready | output | NUM_LP | One-hot accept strobe for the lane taken this cycle |
| rsp_valid | output | 1 | Exclusive store result is present |
| rsp_lp | output | clog2(NUM_LP) | Lane that issued the store being answered |
| rsp_pass | output | 1 | 1 = the exclusive store succeeded |

## Verification
The assertions assume that a lane holds its valid bit, kind and address steady until req_ready accepts it. They also assume that the lane kind is only read while its valid bit is high. The stimulus keeps to both rules: the driver changes a lane only at the falling edge after it has been accepted, and it clears the lane's valid bit at that same edge. The concurrent-store bursts hold every pending lane steady for as many cycles as the priority order needs to drain them.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

   // Request kind on each lane
   typedef enum logic [1:0] {
      KIND_NOP    = 2'b00,
      KIND_XLOAD  = 2'b01,
      KIND_XSTORE = 2'b10,
      KIND_STORE  = 2'b11
   } excl_kind_e;

endpackage

// File: rtl/excl_mon_arb.sv
// Fixed-order arbiter: lowest valid lane wins
module excl_mon_arb #(
   parameter int NUM_LP = 8,
   localparam int ID_W = (NUM_LP > 1) ? $clog2(NUM_LP) : 1
) (
   input  logic [NUM_LP-1:0] req_valid,
   output logic [NUM_LP-1:0] grant,
   output logic [ID_W-1:0]   gnt_id,
   output logic              gnt_any
);

   logic found;

   always_comb begin
      grant  = '0;
      gnt_id = '0;
      found  = 1'b0;
      for (int i = 0; i < NUM_LP; i++) begin
         if (req_valid[i] && !found) begin
            grant[i] = 1'b1;
            gnt_id   = ID_W'(i);
            found    = 1'b1;
         end
      end
   end

   assign gnt_any = found;

endmodule

// File: rtl/excl_mon_resv.sv
// One reservation record: valid flag plus line tag
module excl_mon_resv #(
   parameter int TAG_W = 42
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [TAG_W-1:0] tag_in,
   output logic             vld_o,
   output logic [TAG_W-1:0] tag_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         tag_o <= '0;
      end else if (set_en) begin
         vld_o <= 1'b1;
         tag_o <= tag_in;
      end else if (clr_en && vld_o && (tag_o == tag_in)) begin
         vld_o <= 1'b0;
      end
   end

endmodule

// File: rtl/excl_mon_poc.sv
module excl_mon_poc
   import excl_mon_pkg::*;
#(
   parameter int NUM_LP     = 8,
   parameter int ADDR_W     = 48,
   parameter int LINE_BYTES = 64,
   localparam int ID_W  = (NUM_LP > 1) ? $clog2(NUM_LP) : 1,
   localparam int OFS_W = $clog2(LINE_BYTES),
   localparam int TAG_W = ADDR_W - OFS_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_LP-1:0]        req_valid,
   input  logic [2*NUM_LP-1:0]      req_kind,
   input  logic [ADDR_W*NUM_LP-1:0] req_addr,
   output logic [NUM_LP-1:0]        req_ready,
   output logic                     rsp_valid,
   output logic [ID_W-1:0]          rsp_lp,
   output logic                     rsp_pass
);

   // Elaboration-time parameter checks
   if (NUM_LP < 2) begin : g_bad_lp
      $error("excl_mon_poc: NUM_LP must be at least 2");
   end
   if ((1 << OFS_W) != LINE_BYTES) begin : g_bad_line
      $error("excl_mon_poc: LINE_BYTES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("excl_mon_poc: ADDR_W must exceed the line offset width");
   end

   logic [NUM_LP-1:0] grant;
   logic [ID_W-1:0]   gnt_id;
   logic              gnt_any;

   excl_mon_arb #(.NUM_LP(NUM_LP)) arb_i (
      .req_valid (req_valid),
      .grant     (grant),
      .gnt_id    (gnt_id),
      .gnt_any   (gnt_any)
   );

   assign req_ready = grant;

   // Select kind and line tag of the accepted lane
   excl_kind_e        sel_kind;
   logic [TAG_W-1:0]  sel_tag;

   always_comb begin
      sel_kind = KIND_NOP;
      sel_tag  = '0;
      for (int i = 0; i < NUM_LP; i++) begin
         if (grant[i]) begin
            sel_kind = excl_kind_e'(req_kind[2*i +: 2]);
            sel_tag  = req_addr[ADDR_W*i + OFS_W +: TAG_W];
         end
      end
   end

   // Byte-offset bits are not part of the line compare
   logic [NUM_LP*OFS_W-1:0] unused_ofs;
   for (genvar i = 0; i < NUM_LP; i++) begin : g_ofs
      assign unused_ofs[i*OFS_W +: OFS_W] = req_addr[ADDR_W*i +: OFS_W];
   end

   // Reservation records
   logic [NUM_LP-1:0] rv;
   logic [TAG_W-1:0]  rt [NUM_LP];
   logic [NUM_LP-1:0] set_en;
   logic [NUM_LP-1:0] clr_en;
   logic              own_hit;
   logic              is_xst;
   logic              is_st;
   logic              is_reserve;

   assign own_hit    = rv[gnt_id] && (rt[gnt_id] == sel_tag);
   assign is_xst     = gnt_any && (sel_kind == KIND_XSTORE);
   assign is_st      = gnt_any && (sel_kind == KIND_STORE);
   assign is_reserve = gnt_any && ((sel_kind == KIND_XLOAD) || (sel_kind == KIND_XSTORE));

   for (genvar j = 0; j < NUM_LP; j++) begin : g_resv
      assign set_en[j] = is_reserve && grant[j];
      assign clr_en[j] = (is_xst && own_hit && !grant[j]) || is_st;

      excl_mon_resv #(.TAG_W(TAG_W)) resv_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (set_en[j]),
         .clr_en (clr_en[j]),
         .tag_in (sel_tag),
         .vld_o  (rv[j]),
         .tag_o  (rt[j])
      );
   end

   // Result register: one cycle after acceptance
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_lp    <= '0;
         rsp_pass  <= 1'b0;
      end else begin
         rsp_valid <= is_xst;
         rsp_lp    <= gnt_id;
         rsp_pass  <= is_xst && own_hit;
      end
   end

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
   parameter int NUM_LP = 8,
   localparam int ID_W = (NUM_LP > 1) ? $clog2(NUM_LP) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_LP-1:0]   req_valid,
   input logic [2*NUM_LP-1:0] req_kind,
   input logic [NUM_LP-1:0]   req_ready,
   input logic                rsp_valid,
   input logic [ID_W-1:0]     rsp_lp,
   input logic                rsp_pass
);

   logic            acc_st;
   logic [ID_W-1:0] acc_id;

   always_comb begin
      acc_st = 1'b0;
      acc_id = '0;
      for (int i = 0; i < NUM_LP; i++) begin
         if (req_ready[i]) begin
            acc_id = ID_W'(i);
            acc_st = rst_n && (req_kind[2*i +: 2] == 2'b10);
         end
      end
   end

   // R9
   ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   // R9
   ready_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);

   // R9
   ready_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready != '0) |-> ((req_valid & (req_ready - 1'b1)) == '0));

   // R9
   ready_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |-> (|req_ready));

   // R11
   store_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_st |=> rsp_valid);

   // R11
   rsp_has_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(acc_st));

   // R11
   rsp_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_lp == $past(acc_id)));

   // R11
   pass_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pass |-> rsp_valid);

endmodule

bind excl_mon_poc excl_mon_chk #(.NUM_LP(NUM_LP)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_lp    (rsp_lp),
   .rsp_pass  (rsp_pass)
);

// File: tb/excl_mon_poc_tb.sv
module excl_mon_poc_tb_top;

   localparam int N  = 8;
   localparam int AW = 48;
   localparam int IW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [2*N-1:0]  req_kind = '0;
   logic [AW*N-1:0] req_addr = '0;
   logic [N-1:0]    req_ready;
   logic            rsp_valid;
   logic [IW-1:0]   rsp_lp;
   logic            rsp_pass;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   excl_mon_poc #(.NUM_LP(N), .ADDR_W(AW), .LINE_BYTES(64)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_addr  (req_addr),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_lp    (rsp_lp),
      .rsp_pass  (rsp_pass)
   );

   // Reference reservation model
   bit             mv [N];
   logic [AW-7:0]  mt [N];

   typedef struct {
      int    id;
      bit    pass;
      string req;
   } exp_t;

   exp_t exp_q [$];

   function automatic void model_apply(int id, logic [1:0] k, logic [AW-1:0] a, string r);
      logic [AW-7:0] tag;
      bit            ok;
      exp_t          e;
      tag = a[AW-1:6];
      case (k)
         2'b01: begin
            mv[id] = 1'b1;
            mt[id] = tag;
         end
         2'b10: begin
            ok = mv[id] && (mt[id] == tag);
            if (ok) begin
               for (int j = 0; j < N; j++)
                  if (j != id && mv[j] && mt[j] == tag) mv[j] = 1'b0;
            end
            mv[id] = 1'b1;
            mt[id] = tag;
            e.id = id; e.pass = ok; e.req = r;
            exp_q.push_back(e);
         end
         2'b11: begin
            for (int j = 0; j < N; j++)
               if (mv[j] && mt[j] == tag) mv[j] = 1'b0;
         end
         default: ;
      endcase
   endfunction

   task automatic check_eq(string r, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   // Single-lane request; R9 accept strobe checked as it is presented
   task automatic issue(int id, logic [1:0] k, logic [AW-1:0] a, string r);
      @(negedge clk);
      req_valid = '0;
      req_valid[id] = 1'b1;
      req_kind[2*id +: 2] = k;
      req_addr[AW*id +: AW] = a;
      model_apply(id, k, a, r);
      #1;
      check_eq("R9", "req_ready", longint'(req_ready), longint'(1 << id));
      @(negedge clk);
      req_valid = '0;
   endtask

   // Several lanes at once, all same kind and address
   task automatic burst(logic [N-1:0] mask, logic [1:0] k, logic [AW-1:0] a, string r);
      logic [N-1:0] pend;
      int           g;
      @(negedge clk);
      pend = mask;
      for (int i = 0; i < N; i++) begin
         if (mask[i]) begin
            req_kind[2*i +: 2] = k;
            req_addr[AW*i +: AW] = a;
         end
      end
      req_valid = mask;
      while (pend != '0) begin
         g = 0;
         for (int i = N - 1; i >= 0; i--) if (pend[i]) g = i;
         #1;
         check_eq("R9", "burst req_ready", longint'(req_ready), longint'(1 << g));
         model_apply(g, k, a, r);
         @(negedge clk);
         req_valid[g] = 1'b0;
         pend[g] = 1'b0;
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R11 unexpected response: actual lane %0d expected none", rsp_lp);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check_eq(e.req, "rsp_lp", longint'(rsp_lp), longint'(e.id));
               check_eq(e.req, "rsp_pass", longint'(rsp_pass), longint'(e.pass));
            end
         end else begin
            // R11: result must be out the cycle after acceptance
            if (exp_q.size() != 0 && req_valid == '0) begin
               checks++;
               errors++;
               $display("FAIL R11 missing response: actual none expected lane %0d", exp_q[0].id);
               void'(exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         mv[i] = 1'b0;
         mt[i] = '0;
      end
      repeat (4) @(negedge clk);
      // R12: outputs idle in reset
      check_eq("R12", "rsp_valid in reset", longint'(rsp_valid), 0);
      check_eq("R12", "req_ready idle", longint'(req_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: nothing reserved after reset
      issue(3, 2'b10, 48'h0000_0000_2000, "R12");
      // R1 / R3: load then store on same line
      issue(0, 2'b01, 48'h0000_0000_1000, "R1");
      issue(0, 2'b10, 48'h0000_0000_1000, "R3");
      // R4: store with no reservation fails, the store itself then reserves (R1)
      issue(1, 2'b10, 48'h0000_0000_4000, "R4");
      issue(1, 2'b10, 48'h0000_0000_4000, "R1");
      // R5: winner clears the competitor
      issue(2, 2'b01, 48'h0000_0000_5000, "R5");
      issue(3, 2'b01, 48'h0000_0000_5000, "R5");
      issue(2, 2'b10, 48'h0000_0000_5000, "R5");
      issue(3, 2'b10, 48'h0000_0000_5000, "R5");
      // R6: same line with other offset passes, next line fails
      issue(4, 2'b01, 48'h0000_0000_6000, "R6");
      issue(4, 2'b10, 48'h0000_0000_603F, "R6");
      issue(4, 2'b01, 48'h0000_0000_6000, "R6");
      issue(4, 2'b10, 48'h0000_0000_6040, "R6");
      // R7: second load replaces first
      issue(5, 2'b01, 48'h0000_0000_7000, "R7");
      issue(5, 2'b01, 48'h0000_0000_7100, "R7");
      issue(5, 2'b10, 48'h0000_0000_7000, "R7");
      // R8: normal store clears all holders, including its sender
      issue(6, 2'b01, 48'h0000_0000_8000, "R8");
      issue(7, 2'b01, 48'h0000_0000_8000, "R8");
      issue(0, 2'b01, 48'h0000_0000_8000, "R8");
      issue(0, 2'b11, 48'h0000_0000_8010, "R8");
      issue(6, 2'b10, 48'h0000_0000_8000, "R8");
      issue(7, 2'b10, 48'h0000_0000_8000, "R8");
      issue(0, 2'b10, 48'h0000_0000_8000, "R8");
      // R10: kind 00 leaves reservations alone and gives no response
      issue(1, 2'b01, 48'h0000_0000_A000, "R10");
      issue(2, 2'b00, 48'h0000_0000_A000, "R10");
      issue(1, 2'b00, 48'h0000_0000_A000, "R10");
      issue(1, 2'b10, 48'h0000_0000_A000, "R10");
      // R2: independent lines held together
      issue(0, 2'b01, 48'h0000_0001_0000, "R2");
      issue(1, 2'b01, 48'h0000_0002_0000, "R2");
      issue(1, 2'b10, 48'h0000_0002_0000, "R2");
      issue(0, 2'b10, 48'h0000_0001_0000, "R2");
      // R9 / R5: all lanes load, then all store in one cycle
      burst('1, 2'b01, 48'h0000_0000_F000, "R9");
      burst('1, 2'b10, 48'h0000_0000_F000, "R9");
      // R9: mixed subset of lanes
      burst(8'b1010_0110, 2'b01, 48'h0000_0003_0000, "R9");
      burst(8'b1010_0100, 2'b10, 48'h0000_0003_0000, "R9");

      repeat (4) @(negedge clk);
      check_eq("R11", "pending responses", longint'(exp_q.size()), 0);
      check_eq("R11", "rsp_pass idle", longint'(rsp_pass), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule